// File: doc/BRIEF.md
# Byte-Serial Command Register Decoder

The block takes control commands from an 8-bit byte-serial bus and turns them into held control flags, loaded configuration registers and routed delay writes. A command opens with a strobe on its first byte and continues on the clock cycles that follow. The first two bytes form a 16-bit address, low byte first. The window that the address falls in sets how many data bytes follow, least significant first: none, one or two.

The low 10 bits of the address are compared against four base/mask windows. The two windows that carry no data hold single-bit control flags. In those windows the lowest address bit is the action: an even address clears its flag and an odd address sets it. A third window holds four configuration registers loaded from 16 bits of data. A fourth window takes one data byte and sends it to one of three delay groups or to a single clock-manager delay. Each command that matches a window gives a one-cycle write-enable pulse carrying the assembled address and data. A command that matches no window is consumed and produces nothing.

Top module: `serial_cmd_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every flag, register, `wr_pulse` and `dly_we` is 0. The decoder then waits for a strobe.
- R2: `wr_pulse` is high for exactly one cycle, the cycle after the last byte of a matched command. In that cycle `wr_addr` is {second byte, first byte}. `wr_data` holds the data bytes with the first at bits 7:0 and the second at bits 15:8. Unused data bits are 0.
- R3: The command length follows the window of the address. Window FA is addr[9:0] & 0x3F0 == 0x020 and window FB is addr[9:0] & 0x3F8 == 0x030: both have no data bytes. Window RG is & 0x3F8 == 0x070 and takes two data bytes. Window DL is & 0x380 == 0x080 and takes one data byte. Bytes that arrive without a strobe after a command completes are ignored.
- R4: In window FA, offset addr[3:0] 0x4/0x5 clears/sets `outen_flag`, 0x6/0x7 clears/sets `memrst_flag`, and 0x8/0x9 clears/sets `clken_flag`. Other offsets change no flag. A flag takes its new value in the cycle after the `wr_pulse`.
- R5: In window FB, offset addr[2:0] 0x0/0x1 clears/sets `ctl_en_flag` and 0x2/0x3 clears/sets `rfsh_en_flag`. Offsets 0x4 to 0x7 change no flag, although `wr_pulse` still occurs.
- R6: In window RG, offset addr[2:0] 0 loads `chan_mask` from data[15:0], 1 loads `rfsh_period` from data[7:0], 2 loads `rfsh_addr` from data[9:0], and 3 loads `stat_ctl` from data[7:0]. Offsets 4 to 7 load nothing. Loaded values appear in the cycle after the `wr_pulse`.
- R7: In window DL, with offset o = addr[6:0], `dly_we` pulses together with `wr_pulse` when o < 0x60 or o == 0x60. It carries `dly_grp` = o[6:5] (value 3 is the clock-manager delay), `dly_idx` = o[4:0] and `dly_val` = data[7:0]. Offsets 0x61 to 0x7F give `wr_pulse` without `dly_we`.
- R8: An address that matches no window takes exactly two bytes and produces no `wr_pulse` and no change of state. Address bits 15:10 take no part in the decode.
- R9: A strobe that arrives before a command has completed discards the partial command, which has no effect. The strobed byte starts a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte | input | 8 | Serial command byte |
| cmd_stb | input | 1 | Marks the first byte of a command |
| wr_pulse | output | 1 | One-cycle write enable for a matched command |
| wr_addr | output | 16 | Assembled address, valid with wr_pulse |
| wr_data | output | 16 | Assembled data, valid with wr_pulse |
| outen_flag | output | 1 | Command/address output enable |
| memrst_flag | output | 1 | Memory reset drive |
| clken_flag | output | 1 | Memory clock enable |
| ctl_en_flag | output | 1 | Controller enable |
| rfsh_en_flag | output | 1 | Refresh enable |
| chan_mask | output | 16 | Per-channel enable mask |
| rfsh_period | output | 8 | Refresh period |
| rfsh_addr | output | 10 | Refresh sequence address |
| stat_ctl | output | 8 | Status control |
| dly_we | output | 1 | Delay load strobe |
| dly_grp | output | 2 | Delay group, 3 = clock-manager delay |
| dly_idx | output | 5 | Delay index within the group |
| dly_val | output | 8 | Delay value |

## Verification
The pulse outputs `wr_pulse` and `dly_we`, with their address, data and delay fields, are due in the one cycle after the edge that samples the command's last byte. Flags and registers change one edge later. The bench model follows this timing. At every clock it takes the byte the decoder has just sampled, sets the expected pulse for the next cycle, and holds the expected state change back until the following edge. Every output is compared against the model at the falling edge of each cycle. Directed checks run after a few idle cycles and cover aborted commands, bytes sent without a strobe, unmatched addresses and reserved offsets.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int DEC_W  = 10;

    localparam logic [DEC_W-1:0] FA_BASE = 10'h020;
    localparam logic [DEC_W-1:0] FA_MASK = 10'h3F0;
    localparam logic [DEC_W-1:0] FB_BASE = 10'h030;
    localparam logic [DEC_W-1:0] FB_MASK = 10'h3F8;
    localparam logic [DEC_W-1:0] RG_BASE = 10'h070;
    localparam logic [DEC_W-1:0] RG_MASK = 10'h3F8;
    localparam logic [DEC_W-1:0] DL_BASE = 10'h080;
    localparam logic [DEC_W-1:0] DL_MASK = 10'h380;

    // flag-pair numbers (offset >> 1) in window FA
    localparam logic [2:0] FA_PAIR_OUTEN  = 3'd2;
    localparam logic [2:0] FA_PAIR_MEMRST = 3'd3;
    localparam logic [2:0] FA_PAIR_CLKEN  = 3'd4;

    localparam int DLY_GROUPS = 3;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_FLAG_A,
        WIN_FLAG_B,
        WIN_REG16,
        WIN_DLY8
    } win_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_AHI,
        ST_D0,
        ST_D1
    } col_st_e;

    typedef struct packed {
        win_e              win;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic win_e decode_win(input logic [DEC_W-1:0] a);
        if ((a & FA_MASK) == FA_BASE) return WIN_FLAG_A;
        if ((a & FB_MASK) == FB_BASE) return WIN_FLAG_B;
        if ((a & RG_MASK) == RG_BASE) return WIN_REG16;
        if ((a & DL_MASK) == DL_BASE) return WIN_DLY8;
        return WIN_NONE;
    endfunction

    function automatic logic [1:0] data_len(input win_e w);
        case (w)
            WIN_REG16: return 2'd2;
            WIN_DLY8:  return 2'd1;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sercmd_collect.sv
module sercmd_collect
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] bus_byte,
    input  logic              bus_stb,
    output logic              done,
    output cmd_t              cmd
);
    col_st_e           st, st_n;
    logic [BYTE_W-1:0] lo_q, lo_n;
    logic [BYTE_W-1:0] d0_q, d0_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              fin;
    cmd_t              fin_cmd;
    win_e              w_cur, w_new;

    always_comb begin
        st_n         = st;
        lo_n         = lo_q;
        d0_n         = d0_q;
        addr_n       = addr_q;
        fin          = 1'b0;
        w_cur        = decode_win(addr_q[DEC_W-1:0]);
        w_new        = decode_win({bus_byte[DEC_W-BYTE_W-1:0], lo_q});
        fin_cmd.win  = w_cur;
        fin_cmd.addr = addr_q;
        fin_cmd.data = '0;
        if (bus_stb) begin
            st_n = ST_AHI;
            lo_n = bus_byte;
        end else begin
            case (st)
                ST_AHI: begin
                    addr_n = {bus_byte, lo_q};
                    if (data_len(w_new) == 2'd0) begin
                        fin          = (w_new != WIN_NONE);
                        fin_cmd.win  = w_new;
                        fin_cmd.addr = {bus_byte, lo_q};
                        st_n         = ST_IDLE;
                    end else begin
                        st_n = ST_D0;
                    end
                end
                ST_D0: begin
                    d0_n = bus_byte;
                    if (data_len(w_cur) == 2'd1) begin
                        fin          = 1'b1;
                        fin_cmd.data = {{(DATA_W-BYTE_W){1'b0}}, bus_byte};
                        st_n         = ST_IDLE;
                    end else begin
                        st_n = ST_D1;
                    end
                end
                ST_D1: begin
                    fin          = 1'b1;
                    fin_cmd.data = {bus_byte, d0_q};
                    st_n         = ST_IDLE;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            lo_q   <= '0;
            d0_q   <= '0;
            addr_q <= '0;
            done   <= 1'b0;
            cmd    <= '0;
        end else begin
            st     <= st_n;
            lo_q   <= lo_n;
            d0_q   <= d0_n;
            addr_q <= addr_n;
            done   <= fin;
            if (fin) cmd <= fin_cmd;
        end
    end
endmodule

// File: rtl/sercmd_flags.sv
module sercmd_flags
    import sercmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done,
    input  win_e       win,
    input  logic [3:0] off,
    output logic       outen,
    output logic       memrst,
    output logic       clken,
    output logic       ctl_en,
    output logic       rfsh_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            outen   <= 1'b0;
            memrst  <= 1'b0;
            clken   <= 1'b0;
            ctl_en  <= 1'b0;
            rfsh_en <= 1'b0;
        end else if (done) begin
            if (win == WIN_FLAG_A) begin
                case (off[3:1])
                    FA_PAIR_OUTEN:  outen  <= off[0];
                    FA_PAIR_MEMRST: memrst <= off[0];
                    FA_PAIR_CLKEN:  clken  <= off[0];
                    default: ;
                endcase
            end else if (win == WIN_FLAG_B && !off[2]) begin
                if (off[1]) rfsh_en <= off[0];
                else        ctl_en  <= off[0];
            end
        end
    end
endmodule

// File: rtl/sercmd_regs.sv
module sercmd_regs
    import sercmd_pkg::*;
#(
    parameter int CHN_W  = 16,
    parameter int PER_W  = 8,
    parameter int RADR_W = 10,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  win_e              win,
    input  logic [2:0]        off,
    input  logic [DATA_W-1:0] data,
    output logic [CHN_W-1:0]  chan_mask,
    output logic [PER_W-1:0]  period,
    output logic [RADR_W-1:0] raddr,
    output logic [STAT_W-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chan_mask <= '0;
            period    <= '0;
            raddr     <= '0;
            stat      <= '0;
        end else if (done && win == WIN_REG16) begin
            case (off)
                3'd0: chan_mask <= data[CHN_W-1:0];
                3'd1: period    <= data[PER_W-1:0];
                3'd2: raddr     <= data[RADR_W-1:0];
                3'd3: stat      <= data[STAT_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sercmd_dly.sv
module sercmd_dly
    import sercmd_pkg::*;
(
    input  logic              done,
    input  win_e              win,
    input  logic [6:0]        off,
    input  logic [BYTE_W-1:0] data,
    output logic              we,
    output logic [1:0]        grp,
    output logic [4:0]        idx,
    output logic [BYTE_W-1:0] val
);
    localparam logic [1:0] CLK_GRP = 2'(DLY_GROUPS);

    always_comb begin
        grp = off[6:5];
        idx = off[4:0];
        val = data;
        we  = done && (win == WIN_DLY8) &&
              ((grp != CLK_GRP) || (idx == 5'd0));
    end
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import sercmd_pkg::*;
#(
    parameter int CHN_W  = 16,
    parameter int PER_W  = 8,
    parameter int RADR_W = 10,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              cmd_stb,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              outen_flag,
    output logic              memrst_flag,
    output logic              clken_flag,
    output logic              ctl_en_flag,
    output logic              rfsh_en_flag,
    output logic [CHN_W-1:0]  chan_mask,
    output logic [PER_W-1:0]  rfsh_period,
    output logic [RADR_W-1:0] rfsh_addr,
    output logic [STAT_W-1:0] stat_ctl,
    output logic              dly_we,
    output logic [1:0]        dly_grp,
    output logic [4:0]        dly_idx,
    output logic [BYTE_W-1:0] dly_val
);
    logic done;
    cmd_t cmd;

    sercmd_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .bus_byte (cmd_byte),
        .bus_stb  (cmd_stb),
        .done     (done),
        .cmd      (cmd)
    );

    sercmd_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .win     (cmd.win),
        .off     (cmd.addr[3:0]),
        .outen   (outen_flag),
        .memrst  (memrst_flag),
        .clken   (clken_flag),
        .ctl_en  (ctl_en_flag),
        .rfsh_en (rfsh_en_flag)
    );

    sercmd_regs #(
        .CHN_W  (CHN_W),
        .PER_W  (PER_W),
        .RADR_W (RADR_W),
        .STAT_W (STAT_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .win       (cmd.win),
        .off       (cmd.addr[2:0]),
        .data      (cmd.data),
        .chan_mask (chan_mask),
        .period    (rfsh_period),
        .raddr     (rfsh_addr),
        .stat      (stat_ctl)
    );

    sercmd_dly u_dly (
        .done (done),
        .win  (cmd.win),
        .off  (cmd.addr[6:0]),
        .data (cmd.data[BYTE_W-1:0]),
        .we   (dly_we),
        .grp  (dly_grp),
        .idx  (dly_idx),
        .val  (dly_val)
    );

    assign wr_pulse = done;
    assign wr_addr  = cmd.addr;
    assign wr_data  = cmd.data;
endmodule

// File: rtl/serial_cmd_decoder_chk.sv
module serial_cmd_decoder_chk
    import sercmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_stb,
    input logic       wr_pulse,
    input logic [9:0] wr_low,
    input logic [4:0] flags,
    input logic [41:0] regs,
    input logic       dly_we,
    input logic [1:0] dly_grp,
    input logic [4:0] dly_idx
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse); // R2

    AST_LAST_BYTE_NO_STB: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> !$past(cmd_stb)); // R9

    AST_PULSE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> decode_win(wr_low) != WIN_NONE); // R8

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_pulse) |-> $stable(flags)); // R4

    AST_ONE_FLAG_MOVES: assert property (@(posedge clk) disable iff (rst)
        $countones(flags ^ $past(flags)) <= 1); // R5

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_pulse) |-> $stable(regs)); // R6

    AST_DLY_WITH_WR: assert property (@(posedge clk) disable iff (rst)
        dly_we |-> wr_pulse); // R7

    AST_DLY_CLK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dly_we && dly_grp == 2'd3 |-> dly_idx == 5'd0); // R7
endmodule

bind serial_cmd_decoder serial_cmd_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_stb  (cmd_stb),
    .wr_pulse (wr_pulse),
    .wr_low   (wr_addr[9:0]),
    .flags    ({outen_flag, memrst_flag, clken_flag, ctl_en_flag, rfsh_en_flag}),
    .regs     ({chan_mask, rfsh_period, rfsh_addr, stat_ctl}),
    .dly_we   (dly_we),
    .dly_grp  (dly_grp),
    .dly_idx  (dly_idx)
);

// File: tb/serial_cmd_decoder_bench.sv
`timescale 1ns/1ps
module serial_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_byte = 8'h00;
    logic        cmd_stb = 1'b0;
    logic        wr_pulse;
    logic [15:0] wr_addr, wr_data;
    logic        outen_flag, memrst_flag, clken_flag, ctl_en_flag, rfsh_en_flag;
    logic [15:0] chan_mask;
    logic [7:0]  rfsh_period, stat_ctl, dly_val;
    logic [9:0]  rfsh_addr;
    logic        dly_we;
    logic [1:0]  dly_grp;
    logic [4:0]  dly_idx;

    serial_cmd_decoder u_serial_cmd_decoder (.*);

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int npulse = 0;
    int cyc = 0;
    bit ended = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_cnt, m_need, m_win;
    logic [7:0]  m_lo;
    logic [15:0] m_addr, m_dat;
    bit          m_pulse, m_dly;
    logic [15:0] e_addr, e_data;
    int          e_grp, e_idx;
    logic [7:0]  e_val;
    bit          p_val;
    int          p_win;
    logic [15:0] p_addr, p_data;
    logic        f_outen, f_memrst, f_clken, f_ctl, f_rfsh;
    logic [15:0] r_mask;
    logic [7:0]  r_per, r_stat;
    logic [9:0]  r_raddr;

    function automatic int bwin(input logic [15:0] a);
        int l = int'(a) % 1024;
        if (l >= 'h20 && l <= 'h2f) return 1;
        if (l >= 'h30 && l <= 'h37) return 2;
        if (l >= 'h70 && l <= 'h77) return 3;
        if (l >= 'h80 && l <= 'hff) return 4;
        return 0;
    endfunction

    function automatic int blen(input int w);
        if (w == 3) return 2;
        if (w == 4) return 1;
        return 0;
    endfunction

    task automatic m_finish();
        int o;
        if (m_win != 0) begin
            m_pulse = 1; e_addr = m_addr; e_data = m_dat;
            p_val = 1; p_win = m_win; p_addr = m_addr; p_data = m_dat;
            if (m_win == 4) begin
                o = int'(m_addr) % 128;
                if (o <= 'h60) begin
                    m_dly = 1; e_grp = o / 32; e_idx = o % 32; e_val = m_dat[7:0];
                end
            end
        end
        m_cnt = 0;
    endtask

    task automatic m_apply();
        int o;
        if (p_win == 1) begin
            o = int'(p_addr) % 16;
            case (o)
                4: f_outen = 0;  5: f_outen = 1;
                6: f_memrst = 0; 7: f_memrst = 1;
                8: f_clken = 0;  9: f_clken = 1;
                default: ;
            endcase
        end else if (p_win == 2) begin
            o = int'(p_addr) % 8;
            case (o)
                0: f_ctl = 0;  1: f_ctl = 1;
                2: f_rfsh = 0; 3: f_rfsh = 1;
                default: ;
            endcase
        end else if (p_win == 3) begin
            o = int'(p_addr) % 8;
            case (o)
                0: r_mask = p_data;
                1: r_per = p_data[7:0];
                2: r_raddr = p_data[9:0];
                3: r_stat = p_data[7:0];
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pulse = 0; m_dly = 0; p_val = 0; m_lo = 0;
            m_addr = 0; m_dat = 0; m_win = 0; m_need = 0;
            f_outen = 0; f_memrst = 0; f_clken = 0; f_ctl = 0; f_rfsh = 0;
            r_mask = 0; r_per = 0; r_raddr = 0; r_stat = 0;
        end else begin
            if (p_val) m_apply();
            p_val = 0; m_pulse = 0; m_dly = 0;
            if (cmd_stb) begin
                m_cnt = 1; m_lo = cmd_byte;
            end else if (m_cnt == 1) begin
                m_addr = {cmd_byte, m_lo};
                m_win = bwin(m_addr); m_need = blen(m_win); m_dat = 0;
                if (m_need == 0) m_finish();
                else m_cnt = 2;
            end else if (m_cnt >= 2) begin
                m_dat = m_dat | (16'(cmd_byte) << (8 * (m_cnt - 2)));
                if (m_cnt - 1 == m_need) m_finish();
                else m_cnt++;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !ended) begin
            if (wr_pulse) npulse++;
            chk("R2 wr_pulse", 64'(wr_pulse), 64'(m_pulse));
            if (m_pulse) begin
                chk("R2 wr_addr", 64'(wr_addr), 64'(e_addr));
                chk("R2 wr_data", 64'(wr_data), 64'(e_data));
            end
            chk("R7 dly_we", 64'(dly_we), 64'(m_dly));
            if (m_dly) chk("R7 dly fields", {dly_grp, dly_idx, dly_val},
                           {2'(e_grp), 5'(e_idx), e_val});
            chk("R4 flags A", {outen_flag, memrst_flag, clken_flag},
                {f_outen, f_memrst, f_clken});
            chk("R5 flags B", {ctl_en_flag, rfsh_en_flag}, {f_ctl, f_rfsh});
            chk("R6 regs", {chan_mask, rfsh_period, rfsh_addr, stat_ctl},
                {r_mask, r_per, r_raddr, r_stat});
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input logic s, input logic [7:0] b);
        @(negedge clk); #2;
        cmd_stb = s; cmd_byte = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 8'h00);
    endtask

    task automatic send(input logic [15:0] a, input int n, input logic [15:0] d);
        put(1'b1, a[7:0]);
        put(1'b0, a[15:8]);
        if (n > 0) put(1'b0, d[7:0]);
        if (n > 1) put(1'b0, d[15:8]);
    endtask

    task automatic finish_run();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            bad++; total++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        int saved;
        idle(4);
        chk("R1 reset outputs", {wr_pulse, dly_we, outen_flag, memrst_flag, clken_flag,
            ctl_en_flag, rfsh_en_flag, chan_mask, rfsh_period, rfsh_addr, stat_ctl}, 64'h0);
        put(1'b0, 8'h00); rst = 1'b0;
        idle(1);
        chk("R1 after release", {wr_pulse, outen_flag, chan_mask}, 64'h0);

        // window FA: sets, with high address bits that take no part (R8)
        send(16'h0025, 0, 0); send(16'hFC27, 0, 0); send(16'h0029, 0, 0);
        idle(2);
        chk("R4 all set", {outen_flag, memrst_flag, clken_flag}, 3'b111);
        send(16'h0024, 0, 0); send(16'h002B, 0, 0); idle(2);
        chk("R4 clear outen, other offset ignored", {outen_flag, memrst_flag, clken_flag}, 3'b011);

        // window FB
        send(16'h0031, 0, 0); send(16'h0033, 0, 0); idle(2);
        chk("R5 set", {ctl_en_flag, rfsh_en_flag}, 2'b11);
        saved = npulse;
        send(16'h0034, 0, 0); send(16'h0036, 0, 0); idle(2);
        chk("R5 reserved offsets pulse", 64'(npulse - saved), 64'd2);
        chk("R5 reserved offsets no change", {ctl_en_flag, rfsh_en_flag}, 2'b11);
        send(16'h0030, 0, 0); idle(1);

        // window RG
        send(16'h0070, 2, 16'hBEEF); send(16'h0071, 2, 16'h1234);
        send(16'h0072, 2, 16'hFFFF); send(16'h0073, 2, 16'hA5C3);
        send(16'h0074, 2, 16'h0000); idle(2);
        chk("R6 chan_mask", 64'(chan_mask), 64'hBEEF);
        chk("R6 period", 64'(rfsh_period), 64'h34);
        chk("R6 raddr", 64'(rfsh_addr), 64'h3FF);
        chk("R6 stat", 64'(stat_ctl), 64'hC3);

        // window DL
        send(16'h0085, 1, 16'h0011); send(16'h00A7, 1, 16'h0022);
        send(16'h00DF, 1, 16'h0033); send(16'h00E0, 1, 16'h0044);
        send(16'h00E1, 1, 16'h0055); idle(2);

        // no match: two bytes consumed, no pulse
        saved = npulse;
        send(16'h0000, 0, 0); send(16'h01FF, 0, 0); send(16'h0035, 0, 0); idle(2);
        chk("R8 unmatched gives no pulse", 64'(npulse - saved), 64'd1);

        // bytes without strobe after a complete command are ignored
        saved = npulse;
        send(16'h0025, 0, 0); put(1'b0, 8'h70); put(1'b0, 8'h00);
        put(1'b0, 8'h12); put(1'b0, 8'h34); idle(2);
        chk("R3 trailing bytes ignored", 64'(npulse - saved), 64'd1);
        chk("R3 mask kept", 64'(chan_mask), 64'hBEEF);

        // abort partial commands
        saved = npulse;
        put(1'b1, 8'h70); put(1'b0, 8'h00); put(1'b0, 8'h99);
        send(16'h0071, 2, 16'h0077);
        put(1'b1, 8'h85); put(1'b0, 8'h00);
        send(16'h0028, 0, 0); idle(2);
        chk("R9 aborted commands", 64'(npulse - saved), 64'd2);
        chk("R9 mask unchanged", 64'(chan_mask), 64'hBEEF);
        chk("R9 period from new command", 64'(rfsh_period), 64'h77);
        chk("R9 clken cleared", 64'(clken_flag), 64'd0);

        // back-to-back commands with no gap
        send(16'h0027, 0, 0); send(16'h0026, 0, 0); send(16'h0070, 2, 16'h0F0F);
        idle(3);
        chk("R2 back-to-back", {memrst_flag, chan_mask}, {1'b0, 16'h0F0F});

        finish_run();
    end
endmodule